// File: doc/BRIEF.md
# Cartridge Work-RAM Routing and Nametable Mirroring Control

This block sits on the CPU side of an enhanced bank-switching cartridge controller. It holds two CPU-writable registers, a RAM configuration register and a mirroring register, and from them it produces everything the cartridge needs to reach a 32 KiB battery-backed work RAM. It also drives the single nametable address line that selects the console's internal video RAM page. It does not contain the bank-select core or the scanline counter.

The configuration register has two personalities. While its "extended" bit (bit 5) is clear it behaves as a classic PRG-RAM protect register: the RAM is visible as one fixed 8 KiB bank at CPU $6000-$7FFF, bit 7 enables it and bit 6 write-protects it. Setting bit 5 switches to the extended personality. Bits 1:0 then pick one of four 8 KiB banks, bit 2 turns the first 8 KiB of pattern space into RAM, and bit 6 becomes an enable for the outer-bank registers. With bit 6 clear, those registers are switched off and CPU $5000-$5FFF is overlaid onto the upper 4 KiB of RAM bank 2. A copy-protection sequence relies on this overlay.

Top module: `wram_mirror_ctl`

## Requirements
- R1: After synchronous reset both registers hold zero. WRAM is then disabled (`wram_ce`=0), `regs_en`=1, `chr_low_ram`=0, and `ciram_a10` follows `ppu_a10`.
- R2: A CPU write reaches the configuration register only when `(cpu_addr & 16'hE001) == 16'hA001`, and reaches the mirroring register only when `(cpu_addr & 16'hE001) == 16'hA000`. This admits aliases such as $A003 and $BFFF. Writes to any other address (e.g. $C001, $E000, $8001) change no output.
- R3: With configuration bit 5 clear, the bank is fixed at 0 (`wram_addr` = {2'b00, `cpu_addr[12:0]`}) and bits 1:0 and 2 have no effect. When bit 6 is set, `wram_we` stays 0 while `wram_ce` may be 1.
- R4: Configuration bit 7 enables the RAM. While it is 0, `wram_ce` and `wram_we` are 0 for every address.
- R5: With bit 5 set, a $6000-$7FFF access gives `wram_addr` = {bits 1:0, `cpu_addr[12:0]`}, and writes are not blocked by bit 6.
- R6: `chr_low_ram` is 1 exactly when configuration bits 5 and 2 are both set.
- R7: When bit 5 is set and bit 6 is clear, `regs_en`=0, and a $5000-$5FFF access maps to `wram_addr` = 15'h5000 | `cpu_addr[11:0]`. Enabled by bit 7, that access also asserts `wram_ce`. In every other state `regs_en`=1 and $5000-$5FFF never asserts `wram_ce`.
- R8: With bit 5 set, mirroring bits 1:0 give: 0 `ciram_a10`=`ppu_a10`, 1 `ciram_a10`=`ppu_a11`, 2 constant 0, 3 constant 1.
- R9: With bit 5 clear, only mirroring bit 0 counts (0: `ppu_a10`, 1: `ppu_a11`); codes 2 and 3 act as 0 and 1.
- R10: Writing $A1 to $A001 sends writes to $5000, $5010 and $5013 into RAM at 15'h5000, 15'h5010 and 15'h5013 with `regs_en`=0. A later $E2 write restores `regs_en`=1, maps $6000 to RAM address 15'h4000 and removes the overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| wram_addr | output | 15 | Work-RAM byte address |
| wram_ce | output | 1 | Work-RAM chip enable |
| wram_we | output | 1 | Work-RAM write enable |
| regs_en | output | 1 | Enable for the outer-bank registers at $5000-$5FFF |
| chr_low_ram | output | 1 | First 8 KiB of pattern space uses RAM |
| ciram_a10 | output | 1 | Nametable page select to internal video RAM |

## Verification
The hardest state to reach is the overlay. It requires the extended bit set, the register-enable bit clear and RAM enabled all at once. It also has to be entered and left through a single register whose other bits change bank and pattern memory as a side effect. The bench walks the configuration register through legacy, extended-with-overlay and extended-without-overlay values, using both the canonical address and its aliases. After each write it probes $5xxx and $6xxx addresses, so the overlay is seen both appearing and disappearing. The protection sequence is then replayed from a fresh reset.

// File: rtl/wram_mirror_pkg.sv
package wram_mirror_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 2;
    localparam int BANK_AW  = 13;
    localparam int WRAM_AW  = BANK_W + BANK_AW;
    localparam int OVL_AW   = 12;

    localparam logic [ADDR_W-1:0] DEC_MASK = 16'hE001;
    localparam logic [ADDR_W-1:0] CFG_HIT  = 16'hA001;
    localparam logic [ADDR_W-1:0] MIR_HIT  = 16'hA000;

    localparam logic [BANK_W-1:0] OVL_BANK = 2'd2;

    typedef struct packed {
        logic              ram_on;
        logic              regs_on;
        logic              ext;
        logic [1:0]        spare;
        logic              chr_ram;
        logic [BANK_W-1:0] bank;
    } cfg_t;

    typedef enum logic [1:0] {
        NT_VERT = 2'd0,
        NT_HORZ = 2'd1,
        NT_LOW  = 2'd2,
        NT_HIGH = 2'd3
    } nt_mode_e;

    function automatic nt_mode_e eff_mode(input logic ext, input logic [1:0] raw);
        return ext ? nt_mode_e'(raw) : nt_mode_e'({1'b0, raw[0]});
    endfunction

endpackage

// File: rtl/wram_cfg_regs.sv
module wram_cfg_regs
    import wram_mirror_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr,
    output cfg_t              cfg,
    output logic [1:0]        mir
);
    logic hit_cfg, hit_mir;

    assign hit_cfg = wr && ((addr & DEC_MASK) == CFG_HIT);
    assign hit_mir = wr && ((addr & DEC_MASK) == MIR_HIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            mir <= '0;
        end else begin
            if (hit_cfg) cfg <= cfg_t'(din);
            if (hit_mir) mir <= din[1:0];
        end
    end
endmodule

// File: rtl/wram_route.sv
module wram_route
    import wram_mirror_pkg::*;
(
    input  cfg_t               cfg,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic               wram_ce,
    output logic               wram_we,
    output logic               regs_en,
    output logic               chr_low_ram
);
    logic              in_win6, in_win5, overlay;
    logic              protect;
    logic [BANK_W-1:0] bank;
    logic [1:0]        unused_spare;

    assign unused_spare = cfg.spare;

    assign in_win6 = (addr[ADDR_W-1:BANK_AW] == 3'b011);
    assign in_win5 = (addr[ADDR_W-1:OVL_AW] == 4'h5);
    assign overlay = cfg.ext && !cfg.regs_on;
    assign protect = !cfg.ext && cfg.regs_on;
    assign bank    = cfg.ext ? cfg.bank : '0;

    always_comb begin
        if (overlay && in_win5)
            wram_addr = {OVL_BANK, 1'b1, addr[OVL_AW-1:0]};
        else
            wram_addr = {bank, addr[BANK_AW-1:0]};
    end

    assign wram_ce     = cfg.ram_on && (in_win6 || (overlay && in_win5));
    assign wram_we     = wram_ce && wr && !protect;
    assign regs_en     = !overlay;
    assign chr_low_ram = cfg.ext && cfg.chr_ram;
endmodule

// File: rtl/nt_select.sv
module nt_select
    import wram_mirror_pkg::*;
(
    input  logic       ext,
    input  logic [1:0] mir,
    input  logic       ppu_a10,
    input  logic       ppu_a11,
    output logic       nt_a10
);
    nt_mode_e mode;

    assign mode = eff_mode(ext, mir);

    always_comb begin
        unique case (mode)
            NT_VERT: nt_a10 = ppu_a10;
            NT_HORZ: nt_a10 = ppu_a11;
            NT_LOW:  nt_a10 = 1'b0;
            NT_HIGH: nt_a10 = 1'b1;
        endcase
    end
endmodule

// File: rtl/wram_mirror_ctl.sv
module wram_mirror_ctl
    import wram_mirror_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_data,
    input  logic               cpu_wr,
    input  logic               ppu_a10,
    input  logic               ppu_a11,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic               wram_ce,
    output logic               wram_we,
    output logic               regs_en,
    output logic               chr_low_ram,
    output logic               ciram_a10
);
    cfg_t       cfg;
    logic [1:0] mir;

    wram_cfg_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .addr (cpu_addr),
        .din  (cpu_data),
        .wr   (cpu_wr),
        .cfg  (cfg),
        .mir  (mir)
    );

    wram_route u_route (
        .cfg         (cfg),
        .addr        (cpu_addr),
        .wr          (cpu_wr),
        .wram_addr   (wram_addr),
        .wram_ce     (wram_ce),
        .wram_we     (wram_we),
        .regs_en     (regs_en),
        .chr_low_ram (chr_low_ram)
    );

    nt_select u_nt (
        .ext     (cfg.ext),
        .mir     (mir),
        .ppu_a10 (ppu_a10),
        .ppu_a11 (ppu_a11),
        .nt_a10  (ciram_a10)
    );
endmodule

// File: rtl/wram_mirror_chk.sv
module wram_mirror_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic [14:0] wram_addr,
    input logic        wram_ce,
    input logic        wram_we,
    input logic        regs_en,
    input logic        chr_low_ram
);
    logic cfg_wr;
    assign cfg_wr = cpu_wr && ((cpu_addr & 16'hE001) == 16'hA001);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (regs_en && !chr_low_ram && !wram_ce));

    p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (rst)
        wram_we |-> wram_ce);

    p_protect_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cpu_data[7:5] == 3'b110) |=> !wram_we);

    p_ram_off_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cpu_data[7]) |=> !wram_ce);

    p_chr_flag_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (chr_low_ram == ($past(cpu_data[5]) && $past(cpu_data[2]))));

    p_overlay_regs_r7: assert property (@(posedge clk) disable iff (rst)
        (wram_ce && cpu_addr[15:12] == 4'h5) |-> (!regs_en && wram_addr[14:12] == 3'b101));
endmodule

bind wram_mirror_ctl wram_mirror_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .cpu_data    (cpu_data),
    .cpu_wr      (cpu_wr),
    .wram_addr   (wram_addr),
    .wram_ce     (wram_ce),
    .wram_we     (wram_we),
    .regs_en     (regs_en),
    .chr_low_ram (chr_low_ram)
);

// File: tb/wram_mirror_ctl_bench.sv
module wram_mirror_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] wa;
        logic [7:0]  wd;
        logic [15:0] pa;
        logic        pwr;
        logic        a10;
        logic        a11;
        logic        ce;
        logic        we;
        logic [14:0] addr;
        logic        regs;
        logic        chr;
        logic        nt;
    } vec_t;

    // state carries from one row to the next, starting at reset
    localparam vec_t VECS [NVEC] = '{
        // R4 legacy enable, bank 0
        '{4'd4, 16'hA001, 8'h80, 16'h6123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 15'h0123, 1'b1, 1'b0, 1'b1},
        // R3 write protect in legacy
        '{4'd3, 16'hA001, 8'hC0, 16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 15'h1FFF, 1'b1, 1'b0, 1'b0},
        // R9 code 3 in legacy acts as horizontal
        '{4'd9, 16'hA000, 8'h03, 16'h6000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 15'h0000, 1'b1, 1'b0, 1'b1},
        // R3 bank/chr bits ignored in legacy, R4 ram off
        '{4'd3, 16'hA001, 8'h07, 16'h6000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0000, 1'b1, 1'b0, 1'b0},
        // R5 bank 1, R6 chr ram, R7 regs off, R8 single-screen high
        '{4'd5, 16'hA001, 8'hA5, 16'h6ABC, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 15'h2ABC, 1'b0, 1'b1, 1'b1},
        // R7 regs on, no overlay at 5xxx
        '{4'd7, 16'hA001, 8'hE3, 16'h5013, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 15'h7013, 1'b1, 1'b0, 1'b1},
        // R8 single-screen low
        '{4'd8, 16'hA000, 8'h02, 16'h7001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 15'h7001, 1'b1, 1'b0, 1'b0},
        // R2 alias BFFF; R4 overlay needs ram on
        '{4'd2, 16'hBFFF, 8'h20, 16'h5FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 15'h5FFF, 1'b0, 1'b0, 1'b0},
        // R2 alias A003, R9 code 2 in legacy acts as vertical
        '{4'd2, 16'hA003, 8'h81, 16'h6004, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 15'h0004, 1'b1, 1'b0, 1'b1},
        // R2 C001 ignored
        '{4'd2, 16'hC001, 8'h00, 16'h6004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 15'h0004, 1'b1, 1'b0, 1'b0},
        // R2 E000 ignored
        '{4'd2, 16'hE000, 8'h03, 16'h6004, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 15'h0004, 1'b1, 1'b0, 1'b1},
        // R2 8001 ignored
        '{4'd2, 16'h8001, 8'hE7, 16'h6004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 15'h0004, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic [14:0] wram_addr;
    logic        wram_ce, wram_we, regs_en, chr_low_ram, ciram_a10;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wram_mirror_ctl u_wram_mirror_ctl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .wram_addr(wram_addr), .wram_ce(wram_ce), .wram_we(wram_we),
        .regs_en(regs_en), .chr_low_ram(chr_low_ram), .ciram_a10(ciram_a10)
    );

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic w, input logic p10, input logic p11);
        cpu_addr = a; cpu_wr = w; ppu_a10 = p10; ppu_a11 = p11;
        #1;
    endtask

    task automatic expect_out(input string tag, input logic ce, input logic we,
                              input logic [14:0] ad, input logic rg, input logic ch, input logic nt);
        checks++;
        if ({wram_ce, wram_we, wram_addr, regs_en, chr_low_ram, ciram_a10} !== {ce, we, ad, rg, ch, nt}) begin
            errors++;
            $display("FAIL %s: got ce=%b we=%b addr=%h regs=%b chr=%b nt=%b, expected ce=%b we=%b addr=%h regs=%b chr=%b nt=%b",
                     tag, wram_ce, wram_we, wram_addr, regs_en, chr_low_ram, ciram_a10,
                     ce, we, ad, rg, ch, nt);
        end
        cpu_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        probe(16'h6000, 1'b1, 1'b1, 1'b0);
        expect_out("R1 reset a10=1", 1'b0, 1'b0, 15'h0000, 1'b1, 1'b0, 1'b1);
        probe(16'h5000, 1'b0, 1'b0, 1'b1);
        expect_out("R1 reset a10=0", 1'b0, 1'b0, 15'h1000, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            cpu_write(VECS[i].wa, VECS[i].wd);
            probe(VECS[i].pa, VECS[i].pwr, VECS[i].a10, VECS[i].a11);
            expect_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                       VECS[i].ce, VECS[i].we, VECS[i].addr,
                       VECS[i].regs, VECS[i].chr, VECS[i].nt);
        end

        // R10 protection sequence from a fresh reset
        do_reset();
        cpu_write(16'hA001, 8'hA1);
        probe(16'h5000, 1'b1, 1'b0, 1'b0);
        expect_out("R10 overlay 5000", 1'b1, 1'b1, 15'h5000, 1'b0, 1'b0, 1'b0);
        cpu_write(16'h5000, 8'h11);
        probe(16'h5010, 1'b1, 1'b0, 1'b0);
        expect_out("R10 overlay 5010", 1'b1, 1'b1, 15'h5010, 1'b0, 1'b0, 1'b0);
        cpu_write(16'h5010, 8'h22);
        probe(16'h5013, 1'b1, 1'b0, 1'b0);
        expect_out("R10 overlay 5013", 1'b1, 1'b1, 15'h5013, 1'b0, 1'b0, 1'b0);
        cpu_write(16'h5013, 8'h33);
        cpu_write(16'hA001, 8'hE2);
        probe(16'h6000, 1'b0, 1'b0, 1'b0);
        expect_out("R10 bank 2 at 6000", 1'b1, 1'b0, 15'h4000, 1'b1, 1'b0, 1'b0);
        probe(16'h5010, 1'b1, 1'b0, 1'b0);
        expect_out("R10 overlay removed", 1'b0, 1'b0, 15'h5010 ^ 15'h0000 | 15'h0000, 1'b1, 1'b0, 1'b0);

        // R1 reset clears extended state
        do_reset();
        probe(16'h6ABC, 1'b1, 1'b0, 1'b1);
        expect_out("R1 reset after ext", 1'b0, 1'b0, 15'h0ABC, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule